// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit processor core. It holds the accumulator and a five-bit status word (sign, zero, auxiliary carry, parity, carry). Each cycle where `opValid` is high, it applies one operation to the accumulator and an 8-bit operand, then updates the accumulator and the flags. The operand arrives already fetched from a register, from memory or from an immediate field. Results are registered and visible one clock after the request.

The operations are:
- add and subtract, each with or without the carry flag;
- the three bitwise functions (AND, XOR, OR);
- a compare that sets flags only;
- complement of the accumulator;
- set carry and complement carry;
- four rotates.

Increment and decrement work on the operand path instead of the accumulator. The stepped value comes back on `stepOut` with a one-cycle `stepValid` pulse, so the surrounding core can write it back where the operand came from.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, and after it, `accOut` is 0x00, `flagsOut` is 0b00000 and `stepValid` is 0.
- R2: An operation is taken on a rising clock edge where `opValid` is 1, and its effect is visible after that edge. With `opValid` at 0, the accumulator and the flags hold and `stepValid` is 0. The opCode values are: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 XOR, 6 OR, 7 compare, 8 complement accumulator, 9 set carry, 10 complement carry, 11 rotate left, 12 rotate right, 13 rotate left through carry, 14 rotate right through carry, 15 increment, 16 decrement.
- R3: Add computes A+operand, and add-with-carry computes A+operand+CY. Both write the low 8 bits to A. CY becomes the carry out of bit 7. AC becomes the carry out of bit 3.
- R4: Subtract computes A−operand, and subtract-with-borrow computes A−operand−CY. Both write the result to A. CY becomes 1 when operand plus borrow-in exceeds A as unsigned values. AC becomes the carry out of bit 3 of the sum A + (bitwise NOT operand) + (1 − borrow-in).
- R5: Compare sets every flag exactly as subtract does and leaves A unchanged. So A above the operand gives CY=0 and Z=0, equal gives CY=0 and Z=1, and A below the operand gives CY=1 and Z=0.
- R6: AND clears CY and sets AC. XOR and OR clear both CY and AC.
- R7: `flagsOut` is {S, Z, AC, P, CY} from bit 4 down to bit 0. S is bit 7 of the result, Z is 1 for a zero result, and P is 1 when the result holds an even number of ones. Opcodes 0 to 7, 15 and 16 update S, Z and P.
- R8: Rotate left moves bit 7 into bit 0 and into CY. Rotate right moves bit 0 into bit 7 and into CY.
- R9: Rotate left through carry moves bit 7 into CY and the old CY into bit 0. Rotate right through carry moves bit 0 into CY and the old CY into bit 7. Every rotate leaves S, Z, AC and P unchanged.
- R10: Set carry forces CY to 1 and complement carry inverts CY. Neither one changes A or any other flag.
- R11: Complement accumulator inverts all eight bits of A and changes no flag.
- R12: Increment and decrement both follow the same rules:
  - `stepOut` becomes operand+1 or operand−1 modulo 256, with `stepValid` high for exactly one cycle.
  - S, Z and P come from that value.
  - AC is 1 for increment when the low nibble of the operand is 0xF, and 1 for decrement when that low nibble is not zero.
  - A and CY are unchanged.
- R13: opCode values 17 to 31 change neither A nor any flag, and raise no `stepValid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Apply opCode on this edge |
| opCode | input | 5 | Operation select (see R2) |
| operand | input | 8 | Second operand, or value to step |
| accOut | output | 8 | Accumulator contents |
| flagsOut | output | 5 | Status flags {S, Z, AC, P, CY} |
| stepOut | output | 8 | Incremented or decremented value |
| stepValid | output | 1 | One-cycle strobe marking stepOut |

## Verification
The hardest case to reach is a carry-dependent path with a known incoming carry. The borrow variant of subtract and the two through-carry rotates all depend on the CY left behind by an earlier operation, and the ports offer no direct way to load CY. The bench therefore sets CY explicitly before each such operation, using the set-carry and complement-carry operations. It loads the accumulator the same way, through an AND with zero followed by an OR, so that every operand-and-carry combination is exercised from a known state. Wrap cases (0xFF+1, 0x00−1, a zero result with a carry out) and all three compare outcomes are driven deliberately.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int OP_W   = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3,
    OP_AND = 5'd4,  OP_XOR = 5'd5,  OP_OR  = 5'd6,  OP_CMP = 5'd7,
    OP_CMA = 5'd8,  OP_STC = 5'd9,  OP_CMC = 5'd10, OP_RLC = 5'd11,
    OP_RRC = 5'd12, OP_RAL = 5'd13, OP_RAR = 5'd14, OP_INC = 5'd15,
    OP_DEC = 5'd16
  } aluOp_e;

  typedef enum logic [2:0] {
    RS_ADDER, RS_AND, RS_XOR, RS_OR, RS_NOT, RS_ROT, RS_CYSET, RS_CYINV
  } resSel_e;

  typedef enum logic [1:0] {CIN_ZERO, CIN_FLAG, CIN_ONE} cinSel_e;

  typedef enum logic [1:0] {ROT_LEFT, ROT_RIGHT, ROT_LEFT_CY, ROT_RIGHT_CY} rotSel_e;

  typedef struct packed {
    resSel_e resSel;
    rotSel_e rotSel;
    cinSel_e cinSel;
    logic    subtract;
    logic    xFromOperand;
    logic    yZero;
    logic    accWe;
    logic    szpWe;
    logic    acWe;
    logic    cyWe;
    logic    stepWe;
  } ctrlStrobes_t;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flags_t;
endpackage

// File: rtl/acc_alu_ctrl.sv
module acc_alu_ctrl
  import acc_alu_pkg::*;
(
  input  logic            opValid,
  input  logic [OP_W-1:0] opCode,
  output ctrlStrobes_t    strobes
);
  always_comb begin
    strobes              = '0;
    strobes.resSel       = RS_ADDER;
    strobes.rotSel       = ROT_LEFT;
    strobes.cinSel       = CIN_ZERO;
    if (opValid) begin
      case (opCode)
        OP_ADD, OP_ADC: begin
          strobes.cinSel = (opCode == OP_ADC) ? CIN_FLAG : CIN_ZERO;
          strobes.accWe  = 1'b1;
          strobes.szpWe  = 1'b1;
          strobes.acWe   = 1'b1;
          strobes.cyWe   = 1'b1;
        end
        OP_SUB, OP_SBB, OP_CMP: begin
          strobes.subtract = 1'b1;
          strobes.cinSel   = (opCode == OP_SBB) ? CIN_FLAG : CIN_ZERO;
          strobes.accWe    = (opCode != OP_CMP);
          strobes.szpWe    = 1'b1;
          strobes.acWe     = 1'b1;
          strobes.cyWe     = 1'b1;
        end
        OP_AND, OP_XOR, OP_OR: begin
          strobes.resSel = (opCode == OP_AND) ? RS_AND :
                           (opCode == OP_XOR) ? RS_XOR : RS_OR;
          strobes.accWe  = 1'b1;
          strobes.szpWe  = 1'b1;
          strobes.acWe   = 1'b1;
          strobes.cyWe   = 1'b1;
        end
        OP_CMA: begin
          strobes.resSel = RS_NOT;
          strobes.accWe  = 1'b1;
        end
        OP_STC: begin
          strobes.resSel = RS_CYSET;
          strobes.cyWe   = 1'b1;
        end
        OP_CMC: begin
          strobes.resSel = RS_CYINV;
          strobes.cyWe   = 1'b1;
        end
        OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
          strobes.resSel = RS_ROT;
          strobes.rotSel = (opCode == OP_RLC) ? ROT_LEFT :
                           (opCode == OP_RRC) ? ROT_RIGHT :
                           (opCode == OP_RAL) ? ROT_LEFT_CY : ROT_RIGHT_CY;
          strobes.accWe  = 1'b1;
          strobes.cyWe   = 1'b1;
        end
        OP_INC, OP_DEC: begin
          strobes.subtract     = (opCode == OP_DEC);
          strobes.cinSel       = CIN_ONE;
          strobes.xFromOperand = 1'b1;
          strobes.yZero        = 1'b1;
          strobes.szpWe        = 1'b1;
          strobes.acWe         = 1'b1;
          strobes.stepWe       = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/acc_alu_datapath.sv
module acc_alu_datapath
  import acc_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] accQ,
  output flags_t            flagsQ,
  output logic [DATA_W-1:0] stepQ,
  output logic              stepValidQ
);
  logic [DATA_W-1:0] xIn, yRaw, yEff, resNext, rotRes;
  logic              cinRaw, cinEff, adderCy, rotCy, acNext, cyNext;
  logic [DATA_W:0]   sumFull;
  logic [NIB_W:0]    nibFull;

  // shared adder: subtract runs as x + ~y + ~borrow
  always_comb begin
    xIn  = strobes.xFromOperand ? operand : accQ;
    yRaw = strobes.yZero ? '0 : operand;
    yEff = strobes.subtract ? ~yRaw : yRaw;
    case (strobes.cinSel)
      CIN_FLAG: cinRaw = flagsQ.cy;
      CIN_ONE:  cinRaw = 1'b1;
      default:  cinRaw = 1'b0;
    endcase
    cinEff  = strobes.subtract ? ~cinRaw : cinRaw;
    sumFull = {1'b0, xIn} + {1'b0, yEff} + {{DATA_W{1'b0}}, cinEff};
    nibFull = {1'b0, xIn[NIB_W-1:0]} + {1'b0, yEff[NIB_W-1:0]} + {{NIB_W{1'b0}}, cinEff};
    adderCy = strobes.subtract ? ~sumFull[DATA_W] : sumFull[DATA_W];
  end

  always_comb begin
    case (strobes.rotSel)
      ROT_LEFT:    begin rotRes = {accQ[DATA_W-2:0], accQ[DATA_W-1]};   rotCy = accQ[DATA_W-1]; end
      ROT_RIGHT:   begin rotRes = {accQ[0], accQ[DATA_W-1:1]};          rotCy = accQ[0];        end
      ROT_LEFT_CY: begin rotRes = {accQ[DATA_W-2:0], flagsQ.cy};        rotCy = accQ[DATA_W-1]; end
      default:     begin rotRes = {flagsQ.cy, accQ[DATA_W-1:1]};        rotCy = accQ[0];        end
    endcase
  end

  always_comb begin
    resNext = sumFull[DATA_W-1:0];
    acNext  = 1'b0;
    cyNext  = 1'b0;
    case (strobes.resSel)
      RS_ADDER: begin acNext = nibFull[NIB_W]; cyNext = adderCy; end
      RS_AND:   begin resNext = accQ & operand; acNext = 1'b1; end
      RS_XOR:   resNext = accQ ^ operand;
      RS_OR:    resNext = accQ | operand;
      RS_NOT:   resNext = ~accQ;
      RS_ROT:   begin resNext = rotRes; cyNext = rotCy; end
      RS_CYSET: cyNext = 1'b1;
      default:  cyNext = ~flagsQ.cy;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accQ       <= '0;
      flagsQ     <= '0;
      stepQ      <= '0;
      stepValidQ <= 1'b0;
    end else begin
      stepValidQ <= strobes.stepWe;
      if (strobes.accWe)  accQ      <= resNext;
      if (strobes.stepWe) stepQ     <= resNext;
      if (strobes.acWe)   flagsQ.ac <= acNext;
      if (strobes.cyWe)   flagsQ.cy <= cyNext;
      if (strobes.szpWe) begin
        flagsQ.s <= resNext[DATA_W-1];
        flagsQ.z <= (resNext == '0);
        flagsQ.p <= ~^resNext;
      end
    end
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] accOut,
  output logic [4:0]        flagsOut,
  output logic [DATA_W-1:0] stepOut,
  output logic              stepValid
);
  ctrlStrobes_t strobes;
  flags_t       flagsQ;

  acc_alu_ctrl ctrl_i (
    .opValid (opValid),
    .opCode  (opCode),
    .strobes (strobes)
  );

  acc_alu_datapath dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .operand    (operand),
    .accQ       (accOut),
    .flagsQ     (flagsQ),
    .stepQ      (stepOut),
    .stepValidQ (stepValid)
  );

  assign flagsOut = flagsQ;
endmodule

// File: rtl/acc_alu_checker.sv
module acc_alu_checker
  import acc_alu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              opValid,
  input logic [OP_W-1:0]   opCode,
  input logic [DATA_W-1:0] operand,
  input logic [DATA_W-1:0] accOut,
  input logic [4:0]        flagsOut,
  input logic [DATA_W-1:0] stepOut,
  input logic              stepValid
);
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !opValid |=> (accOut == $past(accOut)) && (flagsOut == $past(flagsOut)) && !stepValid);

  a_r5_cmp_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && opCode == OP_CMP) |=> accOut == $past(accOut));

  a_r6_and_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && opCode == OP_AND) |=> flagsOut[2] && !flagsOut[0]);

  a_r6_or_xor_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && (opCode == OP_OR || opCode == OP_XOR)) |=> !flagsOut[2] && !flagsOut[0]);

  a_r7_logic_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && (opCode == OP_AND || opCode == OP_XOR || opCode == OP_OR))
      |=> (flagsOut[1] == ~^accOut) && (flagsOut[4] == accOut[DATA_W-1]));

  a_r10_set_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && opCode == OP_STC)
      |=> flagsOut[0] && (accOut == $past(accOut)) && (flagsOut[4:1] == $past(flagsOut[4:1])));

  a_r11_complement_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && opCode == OP_CMA)
      |=> (accOut == ~$past(accOut)) && (flagsOut == $past(flagsOut)));

  a_r12_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && opCode == OP_INC)
      |=> stepValid && (stepOut == $past(operand) + 8'd1) && (accOut == $past(accOut))
          && (flagsOut[0] == $past(flagsOut[0])));

  a_r13_unused_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && opCode > OP_DEC)
      |=> (accOut == $past(accOut)) && (flagsOut == $past(flagsOut)) && !stepValid);
endmodule

bind acc_alu acc_alu_checker chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .opValid   (opValid),
  .opCode    (opCode),
  .operand   (operand),
  .accOut    (accOut),
  .flagsOut  (flagsOut),
  .stepOut   (stepOut),
  .stepValid (stepValid)
);

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       opValid = 1'b0;
  logic [4:0] opCode = '0;
  logic [7:0] operand = '0;
  logic [7:0] accOut, stepOut;
  logic [4:0] flagsOut;
  logic       stepValid;

  int vectors = 0;
  int errors  = 0;

  logic [7:0] mA = '0;
  logic [4:0] mF = '0;   // {S,Z,AC,P,CY}

  always #5 clk = ~clk;

  acc_alu dut_i (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opCode(opCode),
    .operand(operand), .accOut(accOut), .flagsOut(flagsOut),
    .stepOut(stepOut), .stepValid(stepValid)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] szp(input logic [7:0] r, input logic ac, input logic cy);
    return {r[7], (r == 8'h00), ac, ~^r, cy};
  endfunction

  // model per requirements, drive one operation, compare all outputs
  task automatic runOp(input string req, input logic [4:0] op, input logic [7:0] v);
    logic [8:0] wide;
    logic [7:0] r, step;
    logic       cy, ac, bin, stepV;
    cy = mF[0]; stepV = 1'b0; step = 8'h00;
    case (op)
      5'd0, 5'd1: begin
        bin  = (op == 5'd1) ? cy : 1'b0;
        wide = {1'b0, mA} + {1'b0, v} + {8'h00, bin};
        r    = wide[7:0];
        ac   = ({1'b0, mA[3:0]} + {1'b0, v[3:0]} + {4'h0, bin}) > 5'h0F;
        mF   = szp(r, ac, wide[8]); mA = r;
      end
      5'd2, 5'd3, 5'd7: begin
        bin = (op == 5'd3) ? cy : 1'b0;
        r   = mA - v - {7'h00, bin};
        ac  = ({1'b0, mA[3:0]} + {1'b0, ~v[3:0]} + {4'h0, ~bin}) > 5'h0F;
        mF  = szp(r, ac, ({1'b0, v} + {8'h00, bin}) > {1'b0, mA});
        if (op != 5'd7) mA = r;
      end
      5'd4: begin r = mA & v; mF = szp(r, 1'b1, 1'b0); mA = r; end
      5'd5: begin r = mA ^ v; mF = szp(r, 1'b0, 1'b0); mA = r; end
      5'd6: begin r = mA | v; mF = szp(r, 1'b0, 1'b0); mA = r; end
      5'd8: mA = ~mA;
      5'd9: mF[0] = 1'b1;
      5'd10: mF[0] = ~cy;
      5'd11: begin mF[0] = mA[7]; mA = {mA[6:0], mA[7]}; end
      5'd12: begin mF[0] = mA[0]; mA = {mA[0], mA[7:1]}; end
      5'd13: begin mF[0] = mA[7]; mA = {mA[6:0], cy}; end
      5'd14: begin mF[0] = mA[0]; mA = {cy, mA[7:1]}; end
      5'd15: begin step = v + 8'd1; stepV = 1'b1; mF = szp(step, v[3:0] == 4'hF, cy); end
      5'd16: begin step = v - 8'd1; stepV = 1'b1; mF = szp(step, v[3:0] != 4'h0, cy); end
      default: ;
    endcase
    @(negedge clk);
    opValid = 1'b1; opCode = op; operand = v;
    @(negedge clk);
    opValid = 1'b0;
    check(req, "accOut", accOut, mA);
    check(req, "flagsOut", flagsOut, mF);
    check(req, "stepValid", stepValid, stepV);
    if (stepV) check(req, "stepOut", stepOut, step);
  endtask

  task automatic loadAcc(input string req, input logic [7:0] v);
    runOp(req, 5'd4, 8'h00);
    runOp(req, 5'd6, v);
  endtask

  task automatic setCarry(input string req, input logic c);
    runOp(req, 5'd9, 8'h00);
    if (!c) runOp(req, 5'd10, 8'h00);
  endtask

  task automatic testReset;
    check("R1", "accOut", accOut, 0);
    check("R1", "flagsOut", flagsOut, 0);
    check("R1", "stepValid", stepValid, 0);
  endtask

  task automatic testIdle;   // R2: opValid low holds state
    loadAcc("R2", 8'h3C);
    @(negedge clk);
    opCode = 5'd0; operand = 8'h55;
    @(negedge clk);
    check("R2", "accOut idle", accOut, mA);
    check("R2", "flagsOut idle", flagsOut, mF);
    check("R2", "stepValid idle", stepValid, 0);
  endtask

  task automatic testAdd;    // R3, R7
    loadAcc("R3", 8'h20); runOp("R3", 5'd0, 8'h30);
    loadAcc("R3", 8'hFF); runOp("R3", 5'd0, 8'h01);
    loadAcc("R3", 8'h8E); runOp("R7", 5'd0, 8'h05);
    loadAcc("R3", 8'h50); setCarry("R3", 1'b1); runOp("R3", 5'd1, 8'h20);
    loadAcc("R3", 8'hF0); setCarry("R3", 1'b1); runOp("R3", 5'd1, 8'h0F);
  endtask

  task automatic testSub;    // R4
    loadAcc("R4", 8'h50); runOp("R4", 5'd2, 8'h30);
    loadAcc("R4", 8'h10); runOp("R4", 5'd2, 8'h20);
    loadAcc("R4", 8'h40); setCarry("R4", 1'b1); runOp("R4", 5'd3, 8'h20);
    loadAcc("R4", 8'h20); setCarry("R4", 1'b1); runOp("R4", 5'd3, 8'h20);
    loadAcc("R4", 8'h33); setCarry("R4", 1'b0); runOp("R4", 5'd3, 8'h33);
  endtask

  task automatic testCompare; // R5
    loadAcc("R5", 8'hB8);
    runOp("R5", 5'd7, 8'hB9);
    runOp("R5", 5'd7, 8'hB8);
    runOp("R5", 5'd7, 8'h30);
  endtask

  task automatic testLogic;  // R6, R7
    loadAcc("R6", 8'h55); runOp("R6", 5'd4, 8'hB3);
    loadAcc("R6", 8'hAA); runOp("R6", 5'd5, 8'h2D);
    runOp("R6", 5'd5, mA);
    loadAcc("R6", 8'h55); runOp("R6", 5'd6, 8'hB3);
    setCarry("R6", 1'b1); runOp("R6", 5'd6, 8'h00);
  endtask

  task automatic testRotates; // R8, R9
    loadAcc("R8", 8'h81); runOp("R8", 5'd11, 8'h00); runOp("R8", 5'd11, 8'h00);
    loadAcc("R8", 8'h01); runOp("R8", 5'd12, 8'h00); runOp("R8", 5'd12, 8'h00);
    loadAcc("R9", 8'h80); setCarry("R9", 1'b0); runOp("R9", 5'd13, 8'h00); runOp("R9", 5'd13, 8'h00);
    loadAcc("R9", 8'h02); setCarry("R9", 1'b1); runOp("R9", 5'd14, 8'h00); runOp("R9", 5'd14, 8'h00);
  endtask

  task automatic testCarryOps; // R10, R11
    loadAcc("R10", 8'h00);
    runOp("R10", 5'd9, 8'h00);
    runOp("R10", 5'd10, 8'h00);
    runOp("R10", 5'd10, 8'h00);
    loadAcc("R11", 8'hA5);
    runOp("R11", 5'd8, 8'hFF);
    runOp("R11", 5'd8, 8'h00);
  endtask

  task automatic testStep;   // R12
    loadAcc("R12", 8'h77); setCarry("R12", 1'b1);
    runOp("R12", 5'd15, 8'h10);
    runOp("R12", 5'd15, 8'h0F);
    runOp("R12", 5'd15, 8'hFF);
    setCarry("R12", 1'b0);
    runOp("R12", 5'd16, 8'h00);
    runOp("R12", 5'd16, 8'h01);
    runOp("R12", 5'd16, 8'h20);
    @(negedge clk);
    check("R12", "stepValid drops", stepValid, 0);
  endtask

  task automatic testUnused; // R13
    loadAcc("R13", 8'h6B); setCarry("R13", 1'b1);
    for (int c = 17; c < 32; c += 7) runOp("R13", 5'(c), 8'hFF);
    runOp("R13", 5'd31, 8'h01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testIdle();
    testAdd();
    testSub();
    testCompare();
    testLogic();
    testRotates();
    testCarryOps();
    testStep();
    testUnused();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule